// File: doc/BRIEF.md
# In-Order Commit Queue with Result Forwarding

This block sits between instruction issue and the architectural register file of a pipelined core whose functional units finish in any order. Each issued instruction takes a slot at the tail of a circular queue and receives a tag. Its program counter, destination register and whether it is a store are recorded at that point. A functional unit later returns the result together with an exception flag, addressed by the tag. Only the oldest slot, at the head, may update machine state. A register result is written to the register file and a store is released to memory, one per cycle, once the head slot has its result and no exception. If the head slot carries an exception, nothing is written. The recorded PC is reported and every slot is discarded in the same cycle, so the saved state is precise.

A forwarding lookup port lets issue logic read results that are finished but not yet written back. When a slot is allocated for a destination register, older slots aimed at that register stop taking part in lookups. The newest producer of each register is therefore the only candidate. A lookup reports a miss, so the register file is used, a hit whose value is still pending, so the consumer waits, or a hit with the value.

Occupancy is tracked by a three-state machine:
- `OCC_EMPTY` goes to `OCC_PART` on an allocation.
- `OCC_PART` goes to `OCC_FULL` when an allocation fills the last slot with no retirement in that cycle.
- `OCC_PART` goes to `OCC_EMPTY` when the last slot retires with no allocation in that cycle.
- `OCC_FULL` goes to `OCC_PART` on a retirement with no allocation in that cycle.
- Any state goes to `OCC_EMPTY` on an exception flush.

Top module: `rob_core`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `rf_we`, `mem_we` and `exc_valid` are 0, and every lookup reports `byp_hit`=0.
- R2: Results may be returned in any tag order. `rf_we` pulses for one cycle per register-writing slot, strictly in allocation order, in the cycle after the head slot has received its result. `rf_waddr` and `rf_wdata` carry that slot's destination and result. While the head slot has no result, nothing is written.
- R3: `alloc_tag` names the slot an accepted allocation takes, and a completion with `done_tag` equal to that value fills that slot. `alloc_ready` is 0 while DEPTH slots are occupied.
- R4: A lookup compares `byp_src` with the destination of every eligible slot. Allocating a register-writing slot makes older live slots with the same destination ineligible, so only the newest producer of a register can supply a lookup, even after an older one has completed.
- R5: A lookup that matches a slot without a result gives `byp_hit`=1 and `byp_ready`=0. A matching completed slot gives `byp_hit`=1, `byp_ready`=1 and its result on `byp_data`. No match gives `byp_hit`=0.
- R6: A slot allocated with `alloc_is_store`=1 never writes the register file. At the head, once completed without exception, it pulses `mem_we` with its result on `mem_wdata`. Such a slot never matches a lookup.
- R7: When the head slot has completed with its exception flag set, `exc_valid` is 1 for one cycle with `exc_pc` equal to the PC recorded at allocation. In that cycle `rf_we`, `mem_we` and `alloc_ready` are 0. All slots are discarded, so younger slots never commit and later lookups miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request a slot for an issuing instruction |
| alloc_dest | input | REG_W | Destination register of the issuing instruction |
| alloc_is_store | input | 1 | Issuing instruction is a store |
| alloc_pc | input | PC_W | PC of the issuing instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TAG_W | Tag of the slot being allocated |
| done_valid | input | 1 | A functional unit returns a result |
| done_tag | input | TAG_W | Slot the result belongs to |
| done_data | input | DATA_W | Result value or store data |
| done_exc | input | 1 | The instruction raised an exception |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | REG_W | Register file write address |
| rf_wdata | output | DATA_W | Register file write data |
| mem_we | output | 1 | Store release strobe |
| mem_wdata | output | DATA_W | Store data |
| exc_valid | output | 1 | Precise exception taken at the head |
| exc_pc | output | PC_W | PC of the excepting instruction |
| byp_src | input | REG_W | Source register to look up |
| byp_hit | output | 1 | An eligible slot produces `byp_src` |
| byp_ready | output | 1 | The matching slot has its result |
| byp_data | output | DATA_W | Forwarded result |

## Verification
The bench builds the block with DEPTH=4, DATA_W=16 and PC_W=16. REG_W keeps its default of 5. The shallow queue makes the full condition reachable within four allocations, and tags wrap around the ring several times within one short run, so the head and tail wrap paths are exercised. The narrower data and PC fields keep the expected values readable while still telling neighbouring slots apart.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_e;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             can_take
);
    localparam int CNT_W = TAG_W + 1;

    occ_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // occupancy counter
    always_comb begin
        cnt_nxt = cnt;
        if (flush)              cnt_nxt = '0;
        else if (push && !pop)  cnt_nxt = cnt + 1'b1;
        else if (pop && !push)  cnt_nxt = cnt - 1'b1;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        if (flush) begin
            state_nxt = OCC_EMPTY;
        end else begin
            unique case (state)
                OCC_EMPTY: if (push) state_nxt = (DEPTH == 1) ? OCC_FULL : OCC_PART;
                OCC_PART: begin
                    if (push && !pop && cnt == CNT_W'(DEPTH - 1)) state_nxt = OCC_FULL;
                    else if (pop && !push && cnt == CNT_W'(1))    state_nxt = OCC_EMPTY;
                end
                OCC_FULL:  if (pop && !push) state_nxt = OCC_PART;
                default:   state_nxt = OCC_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            cnt   <= '0;
            head  <= '0;
            tail  <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (flush) begin
                head <= '0;
                tail <= '0;
            end else begin
                if (pop)  head <= step(head);
                if (push) tail <= step(tail);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            OCC_FULL: can_take = 1'b0;
            default:  can_take = !flush;
        endcase
    end

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    a_r3_full_matches_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_FULL) == (cnt == CNT_W'(DEPTH)));
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state == OCC_EMPTY) && (cnt == '0));
endmodule

// File: rtl/rob_byp.sv
module rob_byp #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  src,
    input  logic              ent_elig [DEPTH],
    input  logic              ent_done [DEPTH],
    input  logic [REG_W-1:0]  ent_dest [DEPTH],
    input  logic [DATA_W-1:0] ent_data [DEPTH],
    output logic              hit,
    output logic              ready,
    output logic [DATA_W-1:0] data
);
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = ent_elig[g] && (ent_dest[g] == src);
    end

    always_comb begin
        hit   = 1'b0;
        ready = 1'b0;
        data  = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (match[k]) begin
                hit   = 1'b1;
                ready = ent_done[k];
                data  = ent_data[k];
            end
        end
    end

    // newest-producer rule leaves at most one candidate per register
    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    a_r5_ready_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> hit);
endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int TAG_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [REG_W-1:0]  alloc_dest,
    input  logic              alloc_is_store,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              done_valid,
    input  logic [TAG_W-1:0]  done_tag,
    input  logic [DATA_W-1:0] done_data,
    input  logic              done_exc,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              exc_valid,
    output logic [PC_W-1:0]   exc_pc,
    input  logic [REG_W-1:0]  byp_src,
    output logic              byp_hit,
    output logic              byp_ready,
    output logic [DATA_W-1:0] byp_data
);
    logic              e_valid [DEPTH];
    logic              e_elig  [DEPTH];
    logic              e_done  [DEPTH];
    logic              e_exc   [DEPTH];
    logic              e_store [DEPTH];
    logic [REG_W-1:0]  e_dest  [DEPTH];
    logic [DATA_W-1:0] e_data  [DEPTH];
    logic [PC_W-1:0]   e_pc    [DEPTH];

    logic [TAG_W-1:0] head, tail;
    logic push, pop, flush, can_take, head_fin;

    assign head_fin    = e_valid[head] && e_done[head];
    assign flush       = head_fin && e_exc[head];
    assign pop         = head_fin && !e_exc[head];
    assign alloc_ready = can_take;
    assign push        = alloc_valid && can_take;
    assign alloc_tag   = tail;

    rob_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
        .head(head), .tail(tail), .can_take(can_take)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                e_valid[g] <= 1'b0;
                e_elig[g]  <= 1'b0;
                e_done[g]  <= 1'b0;
                e_exc[g]   <= 1'b0;
                e_store[g] <= 1'b0;
            end else begin
                if (pop && head == TAG_W'(g)) begin
                    e_valid[g] <= 1'b0;
                    e_elig[g]  <= 1'b0;
                end
                if (push && tail == TAG_W'(g)) begin
                    e_valid[g] <= 1'b1;
                    e_elig[g]  <= !alloc_is_store;
                    e_done[g]  <= 1'b0;
                    e_exc[g]   <= 1'b0;
                    e_store[g] <= alloc_is_store;
                    e_dest[g]  <= alloc_dest;
                    e_pc[g]    <= alloc_pc;
                end else if (push && !alloc_is_store && e_valid[g]
                             && e_dest[g] == alloc_dest) begin
                    e_elig[g] <= 1'b0;
                end
                if (done_valid && done_tag == TAG_W'(g) && e_valid[g]) begin
                    e_done[g] <= 1'b1;
                    e_exc[g]  <= done_exc;
                    e_data[g] <= done_data;
                end
            end
        end
    end

    assign rf_we     = pop && !e_store[head];
    assign rf_waddr  = e_dest[head];
    assign rf_wdata  = e_data[head];
    assign mem_we    = pop && e_store[head];
    assign mem_wdata = e_data[head];
    assign exc_valid = flush;
    assign exc_pc    = e_pc[head];

    rob_byp #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) i_byp (
        .clk(clk), .rst_n(rst_n), .src(byp_src),
        .ent_elig(e_elig), .ent_done(e_done), .ent_dest(e_dest), .ent_data(e_data),
        .hit(byp_hit), .ready(byp_ready), .data(byp_data)
    );

    a_r2_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || mem_we) |=> head == (($past(head) == TAG_W'(DEPTH - 1)) ? '0 : $past(head) + 1'b1));
    a_r7_no_write_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !rf_we && !mem_we && !alloc_ready);
    a_r3_done_hits_live: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> e_valid[done_tag]);
    a_r6_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rf_we);
endmodule

// File: tb/test_rob_core.sv
module test_rob_core;
    localparam int DEPTH = 4, REG_W = 5, DATA_W = 16, PC_W = 16;
    localparam int TAG_W = $clog2(DEPTH);

    logic clk = 0, rst_n = 0;
    logic alloc_valid = 0, alloc_is_store = 0, done_valid = 0, done_exc = 0;
    logic [REG_W-1:0] alloc_dest = '0, byp_src = '0;
    logic [PC_W-1:0] alloc_pc = '0;
    logic [TAG_W-1:0] done_tag = '0;
    logic [DATA_W-1:0] done_data = '0;
    logic alloc_ready, rf_we, mem_we, exc_valid, byp_hit, byp_ready;
    logic [TAG_W-1:0] alloc_tag;
    logic [REG_W-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata, mem_wdata, byp_data;
    logic [PC_W-1:0] exc_pc;

    always #5 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)) i_rob_core (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
        .alloc_is_store(alloc_is_store), .alloc_pc(alloc_pc), .alloc_ready(alloc_ready),
        .alloc_tag(alloc_tag), .done_valid(done_valid), .done_tag(done_tag),
        .done_data(done_data), .done_exc(done_exc), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .mem_we(mem_we), .mem_wdata(mem_wdata), .exc_valid(exc_valid),
        .exc_pc(exc_pc), .byp_src(byp_src), .byp_hit(byp_hit), .byp_ready(byp_ready),
        .byp_data(byp_data)
    );

    typedef struct { int kind; int dest; int val; } exp_t;  // kind 0 reg, 1 store, 2 exception
    exp_t sbq[$];
    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic expect_item(input int kind, input int dest, input int val);
        exp_t e;
        e.kind = kind; e.dest = dest; e.val = val;
        sbq.push_back(e);
    endtask

    // monitor: compare every commit or exception against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (rf_we || mem_we || exc_valid)) begin
            exp_t e;
            int kind;
            kind = exc_valid ? 2 : (mem_we ? 1 : 0);
            if (sbq.size() == 0) begin
                checks++; failures++;
                $display("FAIL R2/R7 unexpected commit kind=%0d actual=%0h expected=none", kind, rf_wdata);
            end else begin
                e = sbq.pop_front();
                chk(kind == 2 ? "R7 kind" : (kind == 1 ? "R6 kind" : "R2 kind"), kind, e.kind);
                if (e.kind == 0) begin
                    chk("R2 waddr", int'(rf_waddr), e.dest);
                    chk("R2 wdata", int'(rf_wdata), e.val);
                end else if (e.kind == 1) begin
                    chk("R6 store data", int'(mem_wdata), e.val);
                end else begin
                    chk("R7 exc_pc", int'(exc_pc), e.val);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic alloc(input int dest, input bit st, input int pc, output int tag);
        alloc_valid = 1; alloc_dest = REG_W'(dest); alloc_is_store = st; alloc_pc = PC_W'(pc);
        @(negedge clk);
        tag = int'(alloc_tag);
        if (!alloc_ready) begin checks++; failures++; $display("FAIL R3 alloc refused actual=0 expected=1"); end
        @(posedge clk); #1;
        alloc_valid = 0;
    endtask

    task automatic complete(input int tag, input int data, input bit exc);
        done_valid = 1; done_tag = TAG_W'(tag); done_data = DATA_W'(data); done_exc = exc;
        @(posedge clk); #1;
        done_valid = 0; done_exc = 0;
    endtask

    task automatic lookup(input int src, input string req, input int hit, input int rdy, input int data);
        byp_src = REG_W'(src);
        #1;
        chk({req, " hit"}, int'(byp_hit), hit);
        if (hit != 0) chk({req, " ready"}, int'(byp_ready), rdy);
        if (rdy != 0) chk({req, " data"}, int'(byp_data), data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int t[8];
        tick(3);
        rst_n = 1;
        #2;
        // R1 reset state
        chk("R1 alloc_ready", int'(alloc_ready), 1);
        chk("R1 rf_we", int'(rf_we), 0);
        chk("R1 mem_we", int'(mem_we), 0);
        chk("R1 exc_valid", int'(exc_valid), 0);
        lookup(1, "R1 lookup", 0, 0, 0);
        tick(1);

        // R2 out-of-order completion, in-order write-back
        alloc(1, 0, 'h10, t[0]); expect_item(0, 1, 'h101);
        alloc(2, 0, 'h14, t[1]); expect_item(0, 2, 'h202);
        alloc(3, 0, 'h18, t[2]); expect_item(0, 3, 'h303);
        complete(t[2], 'h303, 0);
        tick(1);
        chk("R2 no write while head pending", int'(rf_we), 0);
        complete(t[0], 'h101, 0);
        complete(t[1], 'h202, 0);
        tick(4);
        chk("R2 scoreboard drained", sbq.size(), 0);

        // R3 full queue and tag wrap
        for (int i = 0; i < DEPTH; i++) begin
            alloc(10 + i, 0, 'h40 + 4 * i, t[i]);
            expect_item(0, 10 + i, 'h1000 + i);
        end
        chk("R3 full refuses", int'(alloc_ready), 0);
        for (int i = DEPTH - 1; i >= 0; i--) complete(t[i], 'h1000 + i, 0);
        tick(6);
        chk("R3 ready after drain", int'(alloc_ready), 1);
        chk("R3 scoreboard drained", sbq.size(), 0);

        // R4/R5 newest producer forwarding
        alloc(5, 0, 'h80, t[0]); expect_item(0, 5, 'h11);
        alloc(5, 0, 'h84, t[1]); expect_item(0, 5, 'h55);
        lookup(5, "R5 pending", 1, 0, 0);
        lookup(9, "R5 miss", 0, 0, 0);
        done_valid = 0;
        // complete the younger first so the head stays put while the older is still pending
        complete(t[1], 'h55, 0);
        lookup(5, "R4 newest ready", 1, 1, 'h55);
        complete(t[0], 'h11, 0);
        // older completed and now retiring; lookup must still give the newest
        lookup(5, "R4 older ignored", 1, 1, 'h55);
        tick(4);
        lookup(5, "R5 after retire", 0, 0, 0);
        chk("R4 scoreboard drained", sbq.size(), 0);

        // R4 older completed but younger pending -> not ready
        alloc(6, 0, 'h90, t[0]); expect_item(0, 6, 'h66);
        alloc(8, 0, 'h94, t[2]); expect_item(0, 8, 'h88);
        alloc(6, 0, 'h98, t[1]); expect_item(0, 6, 'h67);
        complete(t[2], 'h88, 0);
        complete(t[0], 'h66, 0);
        lookup(6, "R4 young pending", 1, 0, 0);
        complete(t[1], 'h67, 0);
        lookup(6, "R4 young done", 1, 1, 'h67);
        tick(5);
        chk("R4 scoreboard drained 2", sbq.size(), 0);

        // R6 store
        alloc(7, 1, 'hA0, t[0]); expect_item(1, 0, 'h77);
        lookup(7, "R6 store no bypass", 0, 0, 0);
        complete(t[0], 'h77, 0);
        lookup(7, "R6 store done no bypass", 0, 0, 0);
        tick(3);
        chk("R6 scoreboard drained", sbq.size(), 0);

        // R7 precise exception
        alloc(1, 0, 'h100, t[0]); expect_item(0, 1, 'hA);
        alloc(2, 0, 'h200, t[1]); expect_item(2, 0, 'h200);
        alloc(3, 0, 'h300, t[2]);
        complete(t[2], 'hC, 0);
        complete(t[0], 'hA, 0);
        complete(t[1], 'hB, 1);
        chk("R7 exc_valid", int'(exc_valid), 1);
        chk("R7 alloc blocked", int'(alloc_ready), 0);
        chk("R7 no rf write", int'(rf_we), 0);
        tick(1);
        chk("R7 exc one cycle", int'(exc_valid), 0);
        chk("R7 ready after flush", int'(alloc_ready), 1);
        lookup(3, "R7 discarded slot", 0, 0, 0);
        tick(3);
        chk("R7 scoreboard drained", sbq.size(), 0);
        alloc(4, 0, 'h400, t[0]); expect_item(0, 4, 'h44);
        complete(t[0], 'h44, 0);
        tick(3);
        chk("R7 recovery drained", sbq.size(), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule